// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block produces the timing pulses that pace a serial port. An 8-bit divisor, written by software, sets how many system clocks one step of an internal reload timer lasts (divisor + 1). A post-divider then counts those steps. In asynchronous mode it divides by 64 (normal speed) or by 16 (high speed). In synchronous mode it divides by 4, and the high-speed select has no effect there. The result is a bit-rate tick, an oversample tick for an asynchronous receiver, and a shift enable for a synchronous clock master.

Every output is a one-cycle pulse in the system clock domain. No derived clock is produced. A write to the divisor restarts the whole chain, even when the value written is the same. A change of the effective division ratio also restarts it. The first tick after a restart therefore comes one full new period later, not at the end of the period that was running.

The receiver's majority sampling, the shifters and the external slave clocking live elsewhere. This block only supplies the pulses they consume.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `div_value` is 0x00 and no tick is asserted. With the inputs left at 0 after reset, the first `baud_tick` comes in the 64th cycle after release.
- R2: In asynchronous normal-speed mode (`sync_mode`=0, `hi_speed`=0), `baud_tick` pulses once every 64 × (divisor + 1) clock cycles.
- R3: In asynchronous high-speed mode (`sync_mode`=0, `hi_speed`=1), `baud_tick` pulses once every 16 × (divisor + 1) clock cycles.
- R4: In synchronous mode (`sync_mode`=1), `baud_tick` pulses once every 4 × (divisor + 1) cycles, whatever the value of `hi_speed`. Toggling `hi_speed` in this mode neither restarts nor shifts the tick schedule.
- R5: A cycle with `div_wr`=1 loads `div_wdata` into the divisor, which then appears on `div_value`. It also clears the timer and post-divider. The first tick at the new rate comes one full new period after the write edge, counting the cycle after that edge as cycle 1.
- R6: A change of the effective ratio restarts the timing chain in the same way as a divisor write. The effective ratio is one of three: normal-speed asynchronous, high-speed asynchronous, or synchronous.
- R7: In asynchronous modes, `os_tick` pulses 16 times per bit period, every period/16 cycles, and is high in every cycle in which `baud_tick` is high. In synchronous mode `os_tick` stays 0.
- R8: `shift_en` equals `baud_tick` in synchronous mode and stays 0 in asynchronous modes.
- R9: `baud_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Divisor write strobe, one cycle per write |
| div_wdata | input | 8 | Divisor value to write |
| sync_mode | input | 1 | 1 selects synchronous master mode |
| hi_speed | input | 1 | 1 selects the high-speed asynchronous ratio |
| baud_tick | output | 1 | One pulse per bit period |
| os_tick | output | 1 | Receiver oversample pulse, 16 per asynchronous bit |
| shift_en | output | 1 | Synchronous shift-clock enable |
| div_value | output | 8 | Current divisor register contents |

## Verification
The bench goes after restart timing first. It writes the divisor in the middle of a period and also rewrites the same value. A design that waited for the running period to end would place the first new tick late, by up to a whole old period. A design that skipped the restart on an unchanged value would keep the old phase. The bench switches between the three ratios mid-period, and toggles the high-speed select while in synchronous mode. A design that let that select leak into synchronous mode would either change the rate or restart when it should not. The extremes are also covered: divisor 0, which gives a 4-cycle synchronous period and a 1-cycle high-speed oversample step, and divisor 255 at the slowest ratio, which exposes counter widths that are too small.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    RATIO_LO   = 2'd0,
    RATIO_HI   = 2'd1,
    RATIO_SYNC = 2'd2
  } ratio_e;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             sync_sel,
  input  logic             fast_sel,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] load_val,
  output ratio_e           ratio_q,
  output logic             restart
);
  ratio_e           ratio_d;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    if (sync_sel)      ratio_d = RATIO_SYNC;
    else if (fast_sel) ratio_d = RATIO_HI;
    else               ratio_d = RATIO_LO;
    div_d    = wr_en ? wr_data : div_q;
    load_val = div_d;
    restart  = wr_en || (ratio_d != ratio_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ratio_q <= RATIO_LO;
    end else begin
      div_q   <= div_d;
      ratio_q <= ratio_d;
    end
  end

  // the ratio register follows the selects one edge later
  p_ratio_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel) |=> (ratio_q == RATIO_SYNC));

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (div_q == $past(wr_data)));
endmodule

// File: rtl/brg_timer.sv
module brg_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_q,
  output logic             step
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    step = (cnt_q == '0);
    if (restart)   cnt_d = load_val;
    else if (step) cnt_d = div_q;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  p_restart_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/brg_post.sv
module brg_post
  import brg_pkg::*;
#(
  parameter int LO_DIV   = 64,
  parameter int HI_DIV   = 16,
  parameter int SYNC_DIV = 4,
  parameter int OS_RATE  = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   step,
  input  ratio_e ratio_q,
  output logic   baud_tick,
  output logic   os_tick,
  output logic   shift_en
);
  localparam int PW = $clog2(LO_DIV);
  localparam logic [PW-1:0] LO_MAX   = PW'(LO_DIV - 1);
  localparam logic [PW-1:0] HI_MAX   = PW'(HI_DIV - 1);
  localparam logic [PW-1:0] SYNC_MAX = PW'(SYNC_DIV - 1);
  localparam logic [PW-1:0] LO_OSM   = PW'(LO_DIV / OS_RATE - 1);
  localparam logic [PW-1:0] HI_OSM   = PW'(HI_DIV / OS_RATE - 1);

  logic [PW-1:0] cnt_q, cnt_d, cnt_max, os_mask;
  logic          is_async;

  always_comb begin
    is_async = (ratio_q != RATIO_SYNC);
    case (ratio_q)
      RATIO_HI:   begin cnt_max = HI_MAX;   os_mask = HI_OSM; end
      RATIO_SYNC: begin cnt_max = SYNC_MAX; os_mask = '0;     end
      default:    begin cnt_max = LO_MAX;   os_mask = LO_OSM; end
    endcase
    baud_tick = step && (cnt_q == cnt_max);
    os_tick   = step && is_async && ((cnt_q & os_mask) == os_mask);
    shift_en  = baud_tick && !is_async;
    if (restart)        cnt_d = '0;
    else if (baud_tick) cnt_d = '0;
    else if (step)      cnt_d = cnt_q + 1'b1;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_single_baud_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  p_shift_sync_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (ratio_q == RATIO_SYNC));

  p_no_os_in_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RATIO_SYNC) |-> !os_tick);
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import brg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LO_DIV   = 64,
  parameter int HI_DIV   = 16,
  parameter int SYNC_DIV = 4,
  parameter int OS_RATE  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             sync_mode,
  input  logic             hi_speed,
  output logic             baud_tick,
  output logic             os_tick,
  output logic             shift_en,
  output logic [DIV_W-1:0] div_value
);
  logic [DIV_W-1:0] div_q, load_val;
  ratio_e           ratio_q;
  logic             restart, step;

  brg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(div_wr), .wr_data(div_wdata),
    .sync_sel(sync_mode), .fast_sel(hi_speed), .div_q(div_q),
    .load_val(load_val), .ratio_q(ratio_q), .restart(restart)
  );

  brg_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_val(load_val),
    .div_q(div_q), .step(step)
  );

  brg_post #(
    .LO_DIV(LO_DIV), .HI_DIV(HI_DIV), .SYNC_DIV(SYNC_DIV), .OS_RATE(OS_RATE)
  ) u_post (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .ratio_q(ratio_q), .baud_tick(baud_tick), .os_tick(os_tick),
    .shift_en(shift_en)
  );

  assign div_value = div_q;

  p_baud_has_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !shift_en && (ratio_q != RATIO_SYNC)) |-> os_tick);
endmodule

// File: tb/sim_baud_rate_gen.sv
module sim_baud_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr;
  logic [7:0] div_wdata;
  logic       sync_mode;
  logic       hi_speed;
  logic       baud_tick, os_tick, shift_en;
  logic [7:0] div_value;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int c;          // cycle number since last restart, first cycle = 1
  int m_div;
  int m_mult;
  bit prev_baud;

  always #5 clk = ~clk;

  baud_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .sync_mode(sync_mode), .hi_speed(hi_speed), .baud_tick(baud_tick),
    .os_tick(os_tick), .shift_en(shift_en), .div_value(div_value)
  );

  function automatic int mult_of(bit s, bit h);
    if (s) return 4;
    return h ? 16 : 64;
  endfunction

  function automatic string rate_req(int m);
    if (m == 4)  return "R4";
    if (m == 16) return "R3";
    return "R2";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d div=%0d mult=%0d actual=%0d expected=%0d",
               req, c, m_div, m_mult, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // check outputs in the current cycle, then drive next inputs and advance
  task automatic step(bit wr, int d, bit s, bit h);
    int n, eb, eo;
    bit rs;
    n  = m_mult * (m_div + 1);
    eb = (c % n == 0) ? 1 : 0;
    eo = (m_mult != 4 && (c % (n / 16) == 0)) ? 1 : 0;
    chk(rate_req(m_mult), int'(baud_tick), eb);
    chk("R7", int'(os_tick), eo);
    chk("R8", int'(shift_en), (m_mult == 4) ? eb : 0);
    chk("R9", int'(prev_baud && baud_tick), 0);
    chk("R5", int'(div_value), m_div);
    prev_baud = baud_tick;
    div_wr    = wr;
    div_wdata = 8'(d);
    sync_mode = s;
    hi_speed  = h;
    @(posedge clk);
    rs = wr || (mult_of(s, h) != m_mult);
    if (wr) m_div = d;
    m_mult = mult_of(s, h);
    if (rs) c = 1; else c++;
    @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit s, h;
    int d, len, n;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; div_wr = 0; div_wdata = 0; sync_mode = 0; hi_speed = 0;
    prev_baud = 0;
    repeat (3) @(negedge clk);
    // R1: reset contents
    chk("R1", int'(div_value), 0);
    chk("R1", int'(baud_tick | os_tick | shift_en), 0);
    rst_n = 1'b1;
    m_div = 0; m_mult = 64; c = 1;
    chk("R1", int'(baud_tick | os_tick | shift_en), 0);
    for (int i = 0; i < 63; i++) step(0, 0, 0, 0);
    chk("R1", int'(baud_tick), 1);
    for (int i = 0; i < 70; i++) step(0, 0, 0, 0);

    // R4: sync, divisor 0, hi_speed toggled must not disturb schedule
    step(1, 0, 1, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 1, i[2]);

    // R3: high speed, divisor 0 -> oversample every cycle
    step(1, 0, 0, 1);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1);

    // R5: mid-period write of same value restarts phase
    step(1, 5, 0, 1);
    for (int i = 0; i < 50; i++) step(0, 5, 0, 1);
    step(1, 5, 0, 1);
    for (int i = 0; i < 120; i++) step(0, 5, 0, 1);

    // R6: mode change mid-period restarts
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0);
    step(0, 0, 1, 1);
    for (int i = 0; i < 60; i++) step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    for (int i = 0; i < 200; i++) step(0, 0, 0, 1);

    // R2: slowest setting, divisor 255
    step(1, 255, 0, 0);
    for (int i = 0; i < 16400; i++) step(0, 0, 0, 0);

    // random segments with occasional mid-period writes
    for (int seg = 0; seg < 40; seg++) begin
      d = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 20);
      s = $urandom_range(0, 1);
      h = $urandom_range(0, 1);
      step(1, d, s, h);
      n = mult_of(s, h) * (d + 1);
      len = 2 * n + 3;
      if (len > 2000) len = 2000;
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 199) == 0) begin
          d = $urandom_range(0, 20);
          step(1, d, s, h);
        end else if (s && $urandom_range(0, 9) == 0) begin
          h = ~h;
          step(0, 0, s, h);
        end else begin
          step(0, 0, s, h);
        end
      end
    end
    finish_run();
  end
endmodule